// File: doc/BRIEF.md
# Three-Channel PWM Script Loader

This block holds the instruction scripts of three PWM channels and runs a small sequencer for each one. A byte-wide command stream, in which every command opens with a flagged opcode byte, loads 16-bit words into a 60-slot script memory. The same stream starts a channel at a chosen slot or halts it. A channel that is running fetches one word on each cycle in which the shared tick enable is high, then moves its pointer on by one. It presents each fetched word with a one-cycle valid strobe. A zero word, or running off the last slot, ends the channel's program and raises that channel's end-of-program interrupt bit.

Each parameter byte carries two fields. Bits 1:0 hold a channel number from 1 to 3, and bits 7:2 hold a slot address. Commands with an unusable parameter are refused and set an error bit. Interrupt bits are sticky until they are acknowledged.

The command decoder is a state machine with six states:
- `ST_IDLE`: waits for an opcode.
- `ST_WR_PAR`: expects the parameter byte of a write.
- `ST_WR_HI`: expects the upper data byte.
- `ST_WR_LO`: expects the lower data byte.
- `ST_GO_PAR`: expects the parameter byte of a start.
- `ST_HALT_PAR`: expects the parameter byte of a halt.

An opcode byte moves the decoder from any state to the matching parameter state, or to `ST_IDLE` for an opcode it does not know. The transitions on data bytes are:
- A good write parameter moves `ST_WR_PAR` to `ST_WR_HI`. A bad one moves it to `ST_IDLE`.
- `ST_WR_HI` moves to `ST_WR_LO`.
- `ST_WR_LO`, `ST_GO_PAR` and `ST_HALT_PAR` each return to `ST_IDLE`.

Each channel has two states. `CH_IDLE` moves to `CH_RUN` on a start. `CH_RUN` returns to `CH_IDLE` on a halt, on a zero fetch, or after fetching the last slot.

Top module: `pwm_script_loader`

## Requirements
- R1: After reset, all channels are stopped, no fetch strobe is high, the interrupt status is 0x00 and every script slot reads as zero.
- R2: A parameter byte selects channel c-1 through its bits 1:0 (value c in 1..3), and selects slot s through its bits 7:2.
- R3: A write or start parameter whose channel field is 0 or whose slot is above 59 is refused. A halt parameter whose channel field is 0 is refused. A refusal sets interrupt status bit 3, changes no slot and no channel, and causes the remaining data bytes of that command to be ignored.
- R4: A write command (opcode 0xC1) clears the addressed slot when its parameter byte is accepted. The next byte loads bits 15:8 of that slot and the byte after it loads bits 7:0. Any further data bytes are ignored.
- R5: A start command (opcode 0xC2) loads the selected channel's pointer with the slot field and sets that channel running. It restarts the channel if the channel is already running.
- R6: A halt command (opcode 0xC3) stops the selected channel without raising its end interrupt and leaves the other channels unaffected.
- R7: On each clock edge where tick_en is high, every running channel reads the slot at its pointer. For a non-zero word, it raises its fetch_valid bit for the following cycle with that word on its fetch_words lane (lane n is bits 16n+15:16n), then advances its pointer.
- R8: When a running channel fetches a zero word, it stops, gives no fetch strobe and sets interrupt status bit 5+n.
- R9: After a channel delivers the word of slot 59, it stops and sets bit 5+n in the same edge.
- R10: A slot written while a channel is running is seen by that channel's next fetch of the slot.
- R11: A cycle with int_ack high clears all interrupt bits. If a new event happens in that same cycle, the new event's bit survives.
- R12: Data bytes with no open command, and commands with any other opcode, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Command byte present this cycle |
| byte_sof | input | 1 | Marks the present byte as an opcode |
| byte_data | input | 8 | Command byte |
| tick_en | input | 1 | Sequencer step enable shared by all channels |
| int_ack | input | 1 | Clears the interrupt status |
| run | output | 3 | Channel n is running |
| fetch_valid | output | 3 | Channel n delivered a word this cycle |
| fetch_words | output | 48 | Last fetched word of each channel, 16 bits per lane |
| int_status | output | 8 | Bit 3: refused parameter; bit 5+n: channel n ended |

## Verification
The assertions check the following on every cycle:
- A fetch strobe only follows a tick seen by a running channel, and never carries a zero word.
- An end bit only rises together with its channel stopping.
- A channel only starts after a parameter byte.
- The error bit only rises after a byte with a bad field.
- An acknowledge in a quiet cycle empties the status.

Only the bench scenarios can show the following:
- The sequence of fetched words matches what was written.
- A rewrite during a run reaches the next fetch.
- Extra or refused bytes leave memory untouched.
- All 256 start parameter values are decoded correctly.

// File: rtl/pwmsl_pkg.sv
package pwmsl_pkg;

    localparam int CH_NUM  = 3;
    localparam int WORD_W  = 16;
    localparam int SLOT_W  = 6;
    localparam int SEL_W   = 2;
    localparam int ERR_BIT = 3;
    localparam int END_LSB = 5;
    localparam int STAT_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PAR,
        ST_WR_HI,
        ST_WR_LO,
        ST_GO_PAR,
        ST_HALT_PAR
    } cmd_state_t;

    typedef enum logic {
        CH_IDLE,
        CH_RUN
    } ch_state_t;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [SEL_W-1:0]  chan;
    } par_t;

endpackage

// File: rtl/pwmsl_cmd_fsm.sv
module pwmsl_cmd_fsm
    import pwmsl_pkg::*;
#(
    parameter int         SLOTS    = 60,
    parameter logic [7:0] OP_WRITE = 8'hC1,
    parameter logic [7:0] OP_GO    = 8'hC2,
    parameter logic [7:0] OP_HALT  = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              byte_sof,
    input  logic [7:0]        byte_data,
    output logic              mem_clr,
    output logic              mem_hi_we,
    output logic              mem_lo_we,
    output logic [SLOT_W-1:0] mem_slot,
    output logic              go_en,
    output logic              halt_en,
    output logic [SEL_W-1:0]  sel_ch,
    output logic [SLOT_W-1:0] par_slot,
    output logic              bad_par
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    cmd_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    par_t              par;
    logic              data_byte;
    logic              chan_ok;
    logic              full_ok;

    assign par       = par_t'(byte_data);
    assign data_byte = byte_valid && !byte_sof;
    assign chan_ok   = (par.chan != '0);
    assign full_ok   = chan_ok && (par.slot <= LAST);
    assign sel_ch    = par.chan - SEL_W'(1);
    assign par_slot  = par.slot;
    assign mem_slot  = (state_q == ST_WR_PAR) ? par.slot : slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (data_byte && state_q == ST_WR_PAR && full_ok) begin
                slot_q <= par.slot;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (byte_valid && byte_sof) begin
            if (byte_data == OP_WRITE) begin
                state_d = ST_WR_PAR;
            end else if (byte_data == OP_GO) begin
                state_d = ST_GO_PAR;
            end else if (byte_data == OP_HALT) begin
                state_d = ST_HALT_PAR;
            end else begin
                state_d = ST_IDLE;
            end
        end else if (data_byte) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_WR_PAR:   state_d = full_ok ? ST_WR_HI : ST_IDLE;
                ST_WR_HI:    state_d = ST_WR_LO;
                ST_WR_LO:    state_d = ST_IDLE;
                ST_GO_PAR:   state_d = ST_IDLE;
                ST_HALT_PAR: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_clr   = 1'b0;
        mem_hi_we = 1'b0;
        mem_lo_we = 1'b0;
        go_en     = 1'b0;
        halt_en   = 1'b0;
        bad_par   = 1'b0;
        if (data_byte) begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_WR_PAR: begin
                    mem_clr = full_ok;
                    bad_par = !full_ok;
                end
                ST_WR_HI: begin
                    mem_hi_we = 1'b1;
                end
                ST_WR_LO: begin
                    mem_lo_we = 1'b1;
                end
                ST_GO_PAR: begin
                    go_en   = full_ok;
                    bad_par = !full_ok;
                end
                ST_HALT_PAR: begin
                    halt_en = chan_ok;
                    bad_par = !chan_ok;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwmsl_script_mem.sv
module pwmsl_script_mem
    import pwmsl_pkg::*;
#(
    parameter int SLOTS = 60,
    parameter int PORTS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      hi_we,
    input  logic                      lo_we,
    input  logic [SLOT_W-1:0]         wr_slot,
    input  logic [7:0]                wr_byte,
    input  logic [PORTS*SLOT_W-1:0]   rd_addr,
    output logic [PORTS*WORD_W-1:0]   rd_data
);

    logic [WORD_W-1:0] mem_q [SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (32'(wr_slot) < SLOTS) begin
            if (clr) begin
                mem_q[wr_slot] <= '0;
            end else if (hi_we) begin
                mem_q[wr_slot][WORD_W-1:8] <= wr_byte;
            end else if (lo_we) begin
                mem_q[wr_slot][7:0] <= wr_byte;
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        logic [SLOT_W-1:0] a;
        assign a = rd_addr[p*SLOT_W +: SLOT_W];
        assign rd_data[p*WORD_W +: WORD_W] = (32'(a) < SLOTS) ? mem_q[a] : '0;
    end

endmodule

// File: rtl/pwmsl_channel.sv
module pwmsl_channel
    import pwmsl_pkg::*;
#(
    parameter int SLOTS = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              go,
    input  logic              halt,
    input  logic [SLOT_W-1:0] go_slot,
    output logic [SLOT_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_word,
    output logic              running,
    output logic              fetch_valid,
    output logic [WORD_W-1:0] fetch_word,
    output logic              end_now
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    ch_state_t         state_q, state_d;
    logic [SLOT_W-1:0] ptr_q;
    logic              step;

    assign rd_addr = ptr_q;
    assign running = (state_q == CH_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CH_IDLE;
            ptr_q       <= '0;
            fetch_valid <= 1'b0;
            fetch_word  <= '0;
        end else begin
            state_q     <= state_d;
            fetch_valid <= step;
            if (go) begin
                ptr_q <= go_slot;
            end else if (step && ptr_q != LAST) begin
                ptr_q <= ptr_q + SLOT_W'(1);
            end
            if (step) begin
                fetch_word <= rd_word;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        end_now = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (go) begin
                    state_d = CH_RUN;
                end
            end
            CH_RUN: begin
                if (go) begin
                    state_d = CH_RUN;
                end else if (halt) begin
                    state_d = CH_IDLE;
                end else if (tick_en) begin
                    if (rd_word == '0) begin
                        end_now = 1'b1;
                        state_d = CH_IDLE;
                    end else begin
                        step = 1'b1;
                        if (ptr_q == LAST) begin
                            end_now = 1'b1;
                            state_d = CH_IDLE;
                        end
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/pwm_script_loader.sv
module pwm_script_loader
    import pwmsl_pkg::*;
#(
    parameter int         SLOTS    = 60,
    parameter logic [7:0] OP_WRITE = 8'hC1,
    parameter logic [7:0] OP_GO    = 8'hC2,
    parameter logic [7:0] OP_HALT  = 8'hC3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_valid,
    input  logic                     byte_sof,
    input  logic [7:0]               byte_data,
    input  logic                     tick_en,
    input  logic                     int_ack,
    output logic [CH_NUM-1:0]        run,
    output logic [CH_NUM-1:0]        fetch_valid,
    output logic [CH_NUM*WORD_W-1:0] fetch_words,
    output logic [STAT_W-1:0]        int_status
);

    logic                     mem_clr, mem_hi_we, mem_lo_we;
    logic [SLOT_W-1:0]        mem_slot;
    logic                     go_en, halt_en, bad_par;
    logic [SEL_W-1:0]         sel_ch;
    logic [SLOT_W-1:0]        par_slot;
    logic [CH_NUM*SLOT_W-1:0] rd_addr;
    logic [CH_NUM*WORD_W-1:0] rd_data;
    logic [CH_NUM-1:0]        end_vec;
    logic [STAT_W-1:0]        stat_q, stat_set;

    pwmsl_cmd_fsm #(
        .SLOTS(SLOTS), .OP_WRITE(OP_WRITE), .OP_GO(OP_GO), .OP_HALT(OP_HALT)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_sof(byte_sof), .byte_data(byte_data),
        .mem_clr(mem_clr), .mem_hi_we(mem_hi_we), .mem_lo_we(mem_lo_we),
        .mem_slot(mem_slot), .go_en(go_en), .halt_en(halt_en),
        .sel_ch(sel_ch), .par_slot(par_slot), .bad_par(bad_par)
    );

    pwmsl_script_mem #(.SLOTS(SLOTS), .PORTS(CH_NUM)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .clr(mem_clr), .hi_we(mem_hi_we), .lo_we(mem_lo_we),
        .wr_slot(mem_slot), .wr_byte(byte_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
        logic hit;
        assign hit = (sel_ch == SEL_W'(n));
        pwmsl_channel #(.SLOTS(SLOTS)) u_seq (
            .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
            .go(go_en && hit), .halt(halt_en && hit), .go_slot(par_slot),
            .rd_addr(rd_addr[n*SLOT_W +: SLOT_W]),
            .rd_word(rd_data[n*WORD_W +: WORD_W]),
            .running(run[n]), .fetch_valid(fetch_valid[n]),
            .fetch_word(fetch_words[n*WORD_W +: WORD_W]),
            .end_now(end_vec[n])
        );
    end

    always_comb begin
        stat_set = '0;
        stat_set[ERR_BIT] = bad_par;
        stat_set[END_LSB +: CH_NUM] = end_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (int_ack ? '0 : stat_q) | stat_set;
        end
    end

    assign int_status = stat_q;

endmodule

// File: rtl/pwmsl_checker.sv
module pwmsl_checker
    import pwmsl_pkg::*;
#(
    parameter int SLOTS = 60
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     byte_valid,
    input logic                     byte_sof,
    input logic [7:0]               byte_data,
    input logic                     tick_en,
    input logic                     int_ack,
    input logic [CH_NUM-1:0]        run,
    input logic [CH_NUM-1:0]        fetch_valid,
    input logic [CH_NUM*WORD_W-1:0] fetch_words,
    input logic [STAT_W-1:0]        int_status
);

    p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[ERR_BIT]) |->
            $past(byte_valid && !byte_sof &&
                  (byte_data[1:0] == 2'd0 || 32'(byte_data[7:2]) > SLOTS - 1)));

    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !byte_valid && !tick_en) |=> (int_status == '0));

    for (genvar n = 0; n < CH_NUM; n++) begin : g_ap
        p_fetch_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_valid[n] |-> $past(run[n] && tick_en));

        p_fetch_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_valid[n] |-> (fetch_words[n*WORD_W +: WORD_W] != '0));

        p_end_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(int_status[END_LSB+n]) |-> !run[n]);

        p_start_from_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run[n]) |-> $past(byte_valid && !byte_sof));
    end

endmodule

bind pwm_script_loader pwmsl_checker #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/pwm_script_loader_bench.sv
`timescale 1ns/1ps
module pwm_script_loader_bench;

    localparam logic [7:0] OPW = 8'hC1, OPG = 8'hC2, OPH = 8'hC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0, byte_sof = 1'b0, tick_en = 1'b0, int_ack = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [2:0]  run, fetch_valid;
    logic [47:0] fetch_words;
    logic [7:0]  int_status;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [15:0] exp_mem [60];

    always #2.5 clk = ~clk;

    pwm_script_loader u_pwm_script_loader (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
        .byte_data(byte_data), .tick_en(tick_en), .int_ack(int_ack),
        .run(run), .fetch_valid(fetch_valid), .fetch_words(fetch_words),
        .int_status(int_status)
    );

    function automatic logic [15:0] pat(input int s);
        return 16'(((s + 1) << 8) | ((s * 37) & 255));
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic sof, input logic [7:0] d);
        byte_valid = 1'b1; byte_sof = sof; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0; byte_sof = 1'b0;
    endtask

    task automatic wr(input int s, input logic [15:0] w);
        send(1'b1, OPW); send(1'b0, {6'(s), 2'b01}); send(1'b0, w[15:8]); send(1'b0, w[7:0]);
        exp_mem[s] = w;
    endtask

    task automatic go(input int c, input int s);
        send(1'b1, OPG); send(1'b0, {6'(s), 2'(c)});
    endtask

    task automatic halt(input int c);
        send(1'b1, OPH); send(1'b0, {6'd0, 2'(c)});
    endtask

    task automatic tick();
        tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
    endtask

    function automatic logic [15:0] lane(input int n);
        return fetch_words[n*16 +: 16];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run hung actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 60; i++) exp_mem[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "run", 32'(run), 0);
        chk("R1", "fetch_valid", 32'(fetch_valid), 0);
        chk("R1", "status", 32'(int_status), 0);
        // R1 memory cleared: a start at slot 0 ends on first tick (R8)
        go(1, 0);
        tick();
        chk("R1", "fetch after reset", 32'(fetch_valid), 0);
        chk("R8", "end bit ch0", 32'(int_status), 32'h20);
        ack();

        // R4 fill every slot
        for (int s = 0; s < 60; s++) wr(s, pat(s));

        // R7 R9 R2 walk channel 0 across all slots
        go(1, 0);
        for (int k = 0; k < 60; k++) begin
            tick();
            chk("R2", "only lane0 strobes", 32'(fetch_valid), 1);
            chk("R7", "lane0 word", 32'(lane(0)), 32'(pat(k)));
            chk("R9", "run", 32'(run), (k < 59) ? 1 : 0);
            chk("R9", "status", 32'(int_status), (k < 59) ? 0 : 32'h20);
        end
        ack();
        chk("R11", "ack clears", 32'(int_status), 0);

        // R7 R9 two channels together near the end
        go(2, 55);
        go(3, 57);
        for (int k = 0; k < 5; k++) begin
            logic [7:0] es;
            tick();
            chk("R7", "strobes", 32'(fetch_valid), {29'd0, (k < 3), 1'b1, 1'b0});
            chk("R7", "lane1 word", 32'(lane(1)), 32'(pat(55 + k)));
            if (k < 3) chk("R7", "lane2 word", 32'(lane(2)), 32'(pat(57 + k)));
            es = 8'h00;
            if (k >= 2) es[7] = 1'b1;
            if (k >= 4) es[6] = 1'b1;
            chk("R9", "status", 32'(int_status), 32'(es));
            chk("R9", "run", 32'(run), {29'd0, (k < 2), (k < 4), 1'b0});
        end
        // R11 set wins over ack in the same cycle
        go(1, 59);
        int_ack = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        int_ack = 1'b0; tick_en = 1'b0;
        chk("R11", "new end survives ack", 32'(int_status), 32'h20);
        ack();

        // R10 rewrite during run
        go(1, 30);
        tick();
        chk("R10", "slot30", 32'(lane(0)), 32'(pat(30)));
        wr(31, 16'h1234);
        tick();
        chk("R10", "rewritten slot31", 32'(lane(0)), 32'h1234);
        // R6 halt stops, no end interrupt
        halt(1);
        chk("R6", "run after halt", 32'(run), 0);
        tick();
        chk("R6", "no fetch after halt", 32'(fetch_valid), 0);
        chk("R6", "no end bit", 32'(int_status), 0);

        // R8 zero word ends program
        wr(21, 16'h0000);
        go(2, 20);
        tick();
        chk("R8", "slot20", 32'(lane(1)), 32'(pat(20)));
        tick();
        chk("R8", "no strobe on zero", 32'(fetch_valid), 0);
        chk("R8", "status", 32'(int_status), 32'h40);
        chk("R8", "run", 32'(run), 0);
        ack();

        // R4 extra data bytes ignored
        wr(5, 16'hBEEF);
        send(1'b0, 8'h77);
        go(3, 5);
        tick();
        chk("R4", "slot5", 32'(lane(2)), 32'hBEEF);
        halt(3);

        // R3 refused write parameters
        send(1'b1, OPW); send(1'b0, {6'd60, 2'b01});
        chk("R3", "slot 60 refused", 32'(int_status), 32'h08);
        send(1'b0, 8'h11); send(1'b0, 8'h22);
        send(1'b1, OPW); send(1'b0, {6'd5, 2'b00});
        send(1'b0, 8'h33); send(1'b0, 8'h44);
        ack();
        go(3, 5);
        tick();
        chk("R3", "slot5 untouched", 32'(lane(2)), 32'hBEEF);
        // R3 R6 halt with channel 0 refused, other channel keeps running
        send(1'b1, OPH); send(1'b0, 8'h00);
        chk("R3", "halt ch0 refused", 32'(int_status), 32'h08);
        chk("R6", "ch2 still running", 32'(run), 32'h4);
        halt(3);
        ack();

        // R12 stray data and unknown opcode
        send(1'b0, {6'd3, 2'b01});
        send(1'b1, 8'h55); send(1'b0, {6'd3, 2'b01});
        chk("R12", "run", 32'(run), 0);
        chk("R12", "status", 32'(int_status), 0);

        // R5 R3 R2 sweep over every start parameter value
        for (int v = 0; v < 256; v++) begin
            int c, s;
            c = v & 3; s = v >> 2;
            go(c, s);
            if (c != 0 && s < 60) begin
                chk("R5", "run select", 32'(run), 32'(1 << (c - 1)));
                chk("R5", "status", 32'(int_status), 0);
                tick();
                if (exp_mem[s] != 16'h0) begin
                    chk("R5", "pointer word", 32'(lane(c - 1)), 32'(exp_mem[s]));
                    chk("R2", "strobe lane", 32'(fetch_valid), 32'(1 << (c - 1)));
                end else begin
                    chk("R8", "zero start", 32'(int_status), 32'(8'h20 << (c - 1)));
                end
                halt(c);
            end else begin
                chk("R3", "start refused", 32'(int_status), 32'h08);
                chk("R3", "no run", 32'(run), 0);
            end
            ack();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule